// File: doc/BRIEF.md
# Adaptive Link Recovery Poll Scheduler

This block decides when a link-status input is examined and what happens after each look. It counts millisecond ticks down to the next sample. A sample that finds the link up schedules the next one a relaxed interval later. A sample that finds the link down sends a one-cycle reset pulse to the transceiver. It then waits out a hold-off before counting down to the next sample.

The gap after a down sample depends on how long the link has been lost. The first down sample of an outage stamps the start of that outage. While less than a window of milliseconds has passed since that stamp, the next sample comes after a short interval. After the window, it comes after a long interval. An up sample forgets the stamp, so the next outage opens a fresh fast window.

The hold-off length depends on a role input, so that two identical partners do not keep resetting in lock-step. It is never shorter than a fixed stabilisation minimum. Every interval is at least one tick. All durations are parameters in ticks.

Top module: `link_poll_sched`

## Requirements
- R1: While rst_n is low and in the cycle after it is released, sample_stb, xcvr_rst and busy are 0; the first sample falls on the UP_MS-th tick after reset.
- R2: A sample that sees link_up=1 schedules the next sample UP_MS ticks later, with no reset pulse.
- R3: After a down sample, once the hold-off ends, the next sample is FAST_MS ticks later if fewer than WIN_MS ticks have elapsed since the first down sample of the current outage.
- R4: If WIN_MS or more ticks have elapsed since that first down sample when the hold-off ends, the next sample is SLOW_MS ticks later.
- R5: A sample that sees link_up=1 ends the outage, so a later down sample starts a new fast window.
- R6: A sample that sees link_up=0 raises xcvr_rst in the same cycle as sample_stb.
- R7: The hold-off is HOLD_SLV_MS ticks when role_slave=1 and HOLD_MST_MS ticks when role_slave=0, with role_slave taken at the down sample.
- R8: A hold-off is never shorter than MIN_HOLD_MS ticks.
- R9: Any interval parameter below 1 is used as 1 tick.
- R10: busy is 1 from the xcvr_rst cycle until the tick that ends the hold-off, and no sample happens while busy.
- R11: sample_stb and xcvr_rst are single-cycle pulses, raised only on a cycle after an ms_tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| link_up | input | 1 | Link status, 1 = up |
| role_slave | input | 1 | 1 = slave role, 0 = master role |
| sample_stb | output | 1 | Pulse marking a link sample |
| xcvr_rst | output | 1 | Reset pulse to the transceiver |
| busy | output | 1 | High during the post-reset hold-off |

## Verification
A wrong countdown shifts the tick on which sample_stb next appears. That shows up within one interval, at most SLOW_MS or UP_MS ticks. A lost or stale outage stamp shows up as the wrong choice between the fast and slow gap. It appears at the first hold-off that ends near the WIN_MS boundary, or at the first outage after an up sample. A wrong role or hold-off value moves the falling edge of busy. That is seen at the next tick that ends the hold-off.

// File: rtl/link_poll_sched.sv
module link_poll_sched #(
  parameter int UP_MS       = 421,
  parameter int FAST_MS     = 149,
  parameter int WIN_MS      = 6000,
  parameter int SLOW_MS     = 1117,
  parameter int HOLD_MST_MS = 97,
  parameter int HOLD_SLV_MS = 149,
  parameter int MIN_HOLD_MS = 1,
  parameter int CW          = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic link_up,
  input  logic role_slave,
  output logic sample_stb,
  output logic xcvr_rst,
  output logic busy
);
  localparam int MINH   = (MIN_HOLD_MS < 1) ? 1 : MIN_HOLD_MS;
  localparam int UP_I   = (UP_MS   < 1) ? 1 : UP_MS;
  localparam int FAST_I = (FAST_MS < 1) ? 1 : FAST_MS;
  localparam int SLOW_I = (SLOW_MS < 1) ? 1 : SLOW_MS;
  localparam int HM_I   = (HOLD_MST_MS < MINH) ? MINH : HOLD_MST_MS;
  localparam int HS_I   = (HOLD_SLV_MS < MINH) ? MINH : HOLD_SLV_MS;
  localparam int WIN_I  = (WIN_MS < 1) ? 1 : WIN_MS;
  localparam int AW     = $clog2(WIN_I + 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] age;
  logic          hold, down_act;
  logic [AW:0]   elapsed;

  assign elapsed = {1'b0, age} + 1'b1;
  assign busy    = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= CW'(UP_I);
      age        <= '0;
      hold       <= 1'b0;
      down_act   <= 1'b0;
      sample_stb <= 1'b0;
      xcvr_rst   <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      xcvr_rst   <= 1'b0;
      if (ms_tick) begin
        if (down_act && (age < AW'(WIN_I))) age <= age + 1'b1;
        if (cnt > CW'(1)) begin
          cnt <= cnt - 1'b1;
        end else if (!hold) begin
          sample_stb <= 1'b1;
          if (link_up) begin
            cnt      <= CW'(UP_I);
            down_act <= 1'b0;
          end else begin
            xcvr_rst <= 1'b1;
            hold     <= 1'b1;
            cnt      <= role_slave ? CW'(HS_I) : CW'(HM_I);
            if (!down_act) begin
              down_act <= 1'b1;
              age      <= '0;
            end
          end
        end else begin
          hold <= 1'b0;
          cnt  <= (elapsed < (AW+1)'(WIN_I)) ? CW'(FAST_I) : CW'(SLOW_I);
        end
      end
    end
  end

  p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_rst |=> !xcvr_rst);
  p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
  p_rst_with_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_rst |-> sample_stb);
  p_rst_on_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_rst |-> !$past(link_up));
  p_up_no_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !xcvr_rst) |-> $past(link_up));
  p_busy_from_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_rst |-> busy);
  p_no_stb_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xcvr_rst) |-> !sample_stb);
  p_busy_ends_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ms_tick));
endmodule

// File: tb/link_poll_sched_tb_top.sv
module link_poll_sched_tb_top;
  localparam int UP = 21, FAST = 0, WIN = 60, SLOW = 33;
  localparam int HMST = 2, HSLV = 9, MINH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, link_up = 1'b1, role_slave = 1'b0;
  logic sample_stb, xcvr_rst, busy;
  int total = 0, bad = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_poll_sched #(.UP_MS(UP), .FAST_MS(FAST), .WIN_MS(WIN), .SLOW_MS(SLOW),
    .HOLD_MST_MS(HMST), .HOLD_SLV_MS(HSLV), .MIN_HOLD_MS(MINH), .CW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .link_up(link_up),
    .role_slave(role_slave), .sample_stb(sample_stb), .xcvr_rst(xcvr_rst), .busy(busy));

  function automatic int at_least(int v, int lo);
    return (v < lo) ? lo : v;
  endfunction

  // reference state in ticks
  int m_left = UP, m_tnum = 0, m_tfirst = 0;
  bit m_hold = 0, m_dact = 0;
  string m_kind = "R1 R2";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_tick();
    bit es, er;
    string tag;
    es = 0; er = 0; tag = m_kind;
    @(negedge clk) ms_tick = 1'b1;
    m_tnum++;
    if (m_left > 1) begin
      m_left--;
    end else if (!m_hold) begin
      es = 1;
      if (link_up) begin
        if (m_dact) tag = {tag, " R5"};
        m_left = UP; m_dact = 0; m_kind = "R2";
      end else begin
        er = 1; tag = {tag, " R6"};
        if (!m_dact) begin m_dact = 1; m_tfirst = m_tnum; end
        m_hold = 1;
        m_left = role_slave ? at_least(HSLV, MINH) : at_least(HMST, MINH);
        m_kind = role_slave ? "R7" : "R7 R8";
      end
    end else begin
      m_hold = 0;
      if (m_tnum - m_tfirst < WIN) begin m_left = at_least(FAST, 1); m_kind = "R3 R9"; end
      else begin m_left = at_least(SLOW, 1); m_kind = "R4"; end
    end
    @(negedge clk) ms_tick = 1'b0;
    chk(sample_stb == es, tag, "sample_stb", sample_stb, es);
    chk(xcvr_rst == er, tag, "xcvr_rst", xcvr_rst, er);
    chk(busy == m_hold, "R10", "busy", busy, m_hold);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(!sample_stb && !xcvr_rst, "R11", "pulse width", {sample_stb, xcvr_rst}, 0);
    end
  endtask

  task automatic run(int n, bit lk, bit rs);
    link_up = lk; role_slave = rs;
    for (int i = 0; i < n; i++) do_tick();
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    chk(!sample_stb && !xcvr_rst && !busy, "R1", "in reset", {sample_stb, xcvr_rst, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sample_stb && !xcvr_rst && !busy, "R1", "after reset", {sample_stb, xcvr_rst, busy}, 0);
    run(50, 1, 0);
    run(90, 0, 0);
    run(40, 1, 1);
    run(30, 0, 1);
    run(30, 1, 0);
    run(12, 0, 0);
    run(25, 1, 0);
    run(70, 0, 1);
    for (int i = 0; i < 2500; i++) begin
      if ($urandom_range(29, 0) == 0) link_up = ~link_up;
      if ($urandom_range(49, 0) == 0) role_slave = ~role_slave;
      do_tick();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule